// File: doc/BRIEF.md
# Vector Upper-State Frequency License Tracker

This block models the power-license decision logic of a core with a 32-entry, 512-bit vector register file. Each cycle it may receive the descriptor of one retiring instruction. From that descriptor it builds a license request between 0 and 2. The request takes into account:

- the operand width;
- whether the operation is floating-point heavy;
- how densely heavy operations have recently been issued;
- a sticky flag that records whether the upper part of the low sixteen registers holds live data.

The license output rises at once to any higher request. It steps down one level at a time, and only after a programmable number of quiet cycles. A frequency ratio code accompanies each license level. A state-restore strobe reloads the sticky flag from saved context, so the flag can survive a context switch. Clock generation, voltage control and execution are handled elsewhere.

Top module: `vec_license_tracker`

## Requirements
- R1: After a synchronous active-low reset, `license` is 0, `freq_ratio` is 32 and `dirty_upper` is 0.
- R2: A valid instruction that writes a vector register with index 0 to 15 at 512-bit width (`ins_width` = 3) sets `dirty_upper`. The flag is visible in the cycle after the instruction.
- R3: Writes to registers 16 to 31 never set `dirty_upper`. Neither do writes at widths below 512 bits, instructions whose destination is a mask register, or instructions that only read wide registers.
- R4: A valid upper-zeroing instruction clears `dirty_upper`, and that instruction requests no license. A `restore_strobe` loads `dirty_upper` from `restore_dirty` and takes priority over every other update in the same cycle.
- R5: While `dirty_upper` is set, every vector instruction (`ins_vec` = 1) requests at least license 1, including scalar FP, 128-bit and 256-bit integer operations. General-purpose integer instructions (`ins_vec` = 0) request license 0.
- R6: While `dirty_upper` is clear, non-heavy operations at width 0, 1 or 2 (scalar, 128, 256) request license 0. Any vector operation at width 3 (512) requests at least license 1.
- R7: The throughput window spans the current cycle and the 7 cycles before it. A heavy FP operation of width 256 or more requests license 1 when the window holds at least `tp_threshold` such operations. A heavy 512-bit operation requests license 2 when the window holds at least `tp_threshold` heavy 512-bit operations.
- R8: A request above the current license raises `license` to the requested level at the next clock edge, skipping levels if needed.
- R9: The license falls by exactly one level after `hold_cycles` consecutive cycles whose request is below the current level. A request at or above the current level restarts that count.
- R10: `freq_ratio` is 32 for license 0, 28 for license 1 and 24 for license 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | 1 | A retiring instruction is presented this cycle |
| ins_vec | input | 1 | Instruction uses vector registers (0 = general-purpose integer) |
| ins_width | input | 2 | Operand width: 0 scalar, 1 = 128, 2 = 256, 3 = 512 bits |
| ins_fp_heavy | input | 1 | Heavy floating-point operation |
| ins_dst_we | input | 1 | Instruction writes a destination register |
| ins_dst_idx | input | 5 | Destination vector register index |
| ins_dst_mask | input | 1 | Destination is a mask register, not a vector register |
| ins_zero_upper | input | 1 | Instruction zeroes the upper state of all vector registers |
| restore_strobe | input | 1 | Context restore: load the sticky flag from saved state |
| restore_dirty | input | 1 | Saved value of the sticky flag |
| hold_cycles | input | 16 | Quiet cycles required before one step down |
| tp_threshold | input | 4 | Heavy operations per window needed for a throughput request |
| license | output | 2 | Current license level 0..2 |
| freq_ratio | output | 8 | Frequency ratio code for the current license |
| dirty_upper | output | 1 | Sticky upper-dirty flag |

## Verification
The assertions assume that `ins_width` is one of the four codes and that the descriptor fields are meaningful only while `ins_valid` is high. They also assume `hold_cycles` and `tp_threshold` stay fixed while the license is above 0. The bench changes these two settings only right after a reset or while the license is 0, and it drives every descriptor field to zero in idle cycles. Under those conditions, a fall of the license without a preceding quiet request, or a flag change not caused by a restore, a zeroing instruction or a wide write to a low register, points to a fault in the block itself.

// File: rtl/vlt_pkg.sv
// Package vlt_pkg
// Shared encodings for the vector license tracker: operand width codes,
// license level type and the register-file geometry defaults.
// Assumes: widths are encoded in two bits, licenses in two bits.
package vlt_pkg;

    typedef enum logic [1:0] {
        WID_SCALAR = 2'd0,
        WID_128    = 2'd1,
        WID_256    = 2'd2,
        WID_512    = 2'd3
    } wid_e;

    typedef logic [1:0] lic_t;

    localparam lic_t LIC_BASE  = 2'd0;
    localparam lic_t LIC_MID   = 2'd1;
    localparam lic_t LIC_HIGH  = 2'd2;

    localparam int DEF_NUM_REGS = 32;
    localparam int DEF_KEY_REGS = 16;
    localparam int DEF_WINDOW   = 8;

endpackage

// File: rtl/vlt_dirty_tracker.sv
// Module vlt_dirty_tracker
// Holds the sticky upper-dirty flag. Only full-width writes to the key
// (low) registers set it; an upper-zeroing instruction clears it; a context
// restore overrides both with the saved value.
// Assumes: descriptor fields are qualified by ins_valid.
module vlt_dirty_tracker
    import vlt_pkg::*;
#(
    parameter int NUM_REGS = DEF_NUM_REGS,
    parameter int KEY_REGS = DEF_KEY_REGS,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_valid,
    input  logic [1:0]       ins_width,
    input  logic             ins_dst_we,
    input  logic [IDX_W-1:0] ins_dst_idx,
    input  logic             ins_dst_mask,
    input  logic             ins_zero_upper,
    input  logic             restore_strobe,
    input  logic             restore_dirty,
    output logic             dirty
);

    localparam logic [IDX_W-1:0] KEY_LIMIT = IDX_W'(KEY_REGS);

    logic key_wide_write;
    logic clear_req;

    // Decode whether this instruction writes a key register at full width.
    always_comb begin
        key_wide_write = ins_valid && ins_dst_we && !ins_dst_mask
                         && (ins_dst_idx < KEY_LIMIT)
                         && (wid_e'(ins_width) == WID_512);
        clear_req      = ins_valid && ins_zero_upper;
    end

    // Update the sticky flag: restore first, then zeroing, then setting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dirty <= 1'b0;
        end else if (restore_strobe) begin
            dirty <= restore_dirty;
        end else if (clear_req) begin
            dirty <= 1'b0;
        end else if (key_wide_write) begin
            dirty <= 1'b1;
        end
    end

    AST_HIGH_REG_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (!restore_strobe && !dirty && ins_valid && ins_dst_we
         && ins_dst_idx >= KEY_LIMIT) |=> !dirty); // R3

    AST_MASK_DST_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (!restore_strobe && !dirty && ins_valid && ins_dst_mask) |=> !dirty); // R3

    AST_KEY_WIDE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (!restore_strobe && ins_valid && !ins_zero_upper && ins_dst_we && !ins_dst_mask
         && ins_dst_idx < KEY_LIMIT && ins_width == 2'd3) |=> dirty); // R2

    AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!restore_strobe && ins_valid && ins_zero_upper) |=> !dirty); // R4

    AST_RESTORE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        restore_strobe |=> (dirty == $past(restore_dirty))); // R4

endmodule

// File: rtl/vlt_demand.sv
// Module vlt_demand
// Turns the current descriptor, the sticky flag and a sliding window of
// recent heavy operations into a license request for this cycle.
// Assumes: the window covers the current cycle plus WINDOW-1 earlier ones.
module vlt_demand
    import vlt_pkg::*;
#(
    parameter int WINDOW   = DEF_WINDOW,
    localparam int CNT_W   = $clog2(WINDOW + 1),
    localparam int HIST_W  = WINDOW - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_valid,
    input  logic             ins_vec,
    input  logic [1:0]       ins_width,
    input  logic             ins_fp_heavy,
    input  logic             ins_zero_upper,
    input  logic             dirty,
    input  logic [CNT_W-1:0] tp_threshold,
    output lic_t             demand
);

    logic              vec_op;
    logic              heavy_wide;
    logic              heavy_full;
    logic [HIST_W-1:0] hist_wide;
    logic [HIST_W-1:0] hist_full;
    logic [CNT_W-1:0]  cnt_wide;
    logic [CNT_W-1:0]  cnt_full;

    // Classify the current instruction for window accounting.
    always_comb begin
        vec_op     = ins_valid && ins_vec && !ins_zero_upper;
        heavy_wide = vec_op && ins_fp_heavy && (ins_width[1] == 1'b1);
        heavy_full = vec_op && ins_fp_heavy && (wid_e'(ins_width) == WID_512);
    end

    // Shift the per-cycle heavy-op history for both classes.
    generate
        if (HIST_W == 1) begin : g_hist_one
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hist_wide <= '0;
                    hist_full <= '0;
                end else begin
                    hist_wide <= heavy_wide;
                    hist_full <= heavy_full;
                end
            end
        end else begin : g_hist_many
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hist_wide <= '0;
                    hist_full <= '0;
                end else begin
                    hist_wide <= {hist_wide[HIST_W-2:0], heavy_wide};
                    hist_full <= {hist_full[HIST_W-2:0], heavy_full};
                end
            end
        end
    endgenerate

    // Count heavy operations in the window including the current cycle.
    always_comb begin
        cnt_wide = CNT_W'(heavy_wide);
        cnt_full = CNT_W'(heavy_full);
        for (int i = 0; i < HIST_W; i++) begin
            cnt_wide = cnt_wide + CNT_W'(hist_wide[i]);
            cnt_full = cnt_full + CNT_W'(hist_full[i]);
        end
    end

    // Combine flag, width and throughput into the request level.
    always_comb begin
        demand = LIC_BASE;
        if (vec_op) begin
            if (dirty)
                demand = LIC_MID;
            if (wid_e'(ins_width) == WID_512)
                demand = LIC_MID;
            if (heavy_wide && cnt_wide >= tp_threshold)
                demand = LIC_MID;
            if (heavy_full && cnt_full >= tp_threshold)
                demand = LIC_HIGH;
        end
    end

    AST_GP_NO_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !ins_vec) |-> (demand == LIC_BASE)); // R5

    AST_DIRTY_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_vec && !ins_zero_upper && dirty) |-> (demand != LIC_BASE)); // R5

    AST_WIDE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_vec && !ins_zero_upper && ins_width == 2'd3)
        |-> (demand != LIC_BASE)); // R6

    AST_DEMAND_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        demand <= LIC_HIGH); // R7

endmodule

// File: rtl/vlt_license_ctrl.sv
// Module vlt_license_ctrl
// Holds the granted license. A higher request is granted at the next edge;
// a lower request must persist for hold_cycles consecutive cycles before
// the license falls one level, and each further step needs a fresh hold.
// Assumes: hold_cycles stays constant while the license is above zero.
module vlt_license_ctrl
    import vlt_pkg::*;
#(
    parameter int HOLD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  lic_t              demand,
    input  logic [HOLD_W-1:0] hold_cycles,
    output lic_t              license
);

    logic [HOLD_W-1:0] quiet_cnt;
    logic              hold_done;

    // Decide whether this quiet cycle completes the hold interval.
    always_comb begin
        hold_done = ({1'b0, quiet_cnt} + (HOLD_W+1)'(1)) >= {1'b0, hold_cycles};
    end

    // Raise at once, step down by one after the hold interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            license   <= LIC_BASE;
            quiet_cnt <= '0;
        end else if (demand > license) begin
            license   <= demand;
            quiet_cnt <= '0;
        end else if (demand == license || license == LIC_BASE) begin
            quiet_cnt <= '0;
        end else if (hold_done) begin
            license   <= license - lic_t'(1);
            quiet_cnt <= '0;
        end else begin
            quiet_cnt <= quiet_cnt + HOLD_W'(1);
        end
    end

    AST_RISE_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (demand > license) |=> (license == $past(demand))); // R8

    AST_STEP_OF_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (license < $past(license)) |-> (license == $past(license) - lic_t'(1))); // R9

    AST_DROP_NEEDS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (license < $past(license)) |-> ($past(demand) < $past(license))); // R9

    AST_LICENSE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        license <= LIC_HIGH); // R10

endmodule

// File: rtl/vec_license_tracker.sv
// Module vec_license_tracker
// Top of the frequency-license tracker: combines the sticky upper-dirty
// flag, the per-instruction request logic and the hold-based license
// controller, and maps the license to a frequency ratio code.
// Assumes: one retiring-instruction descriptor per cycle at most.
module vec_license_tracker
    import vlt_pkg::*;
#(
    parameter int NUM_REGS   = DEF_NUM_REGS,
    parameter int KEY_REGS   = DEF_KEY_REGS,
    parameter int WINDOW     = DEF_WINDOW,
    parameter int HOLD_W     = 16,
    parameter int RATIO_W    = 8,
    parameter int RATIO_L0   = 32,
    parameter int RATIO_L1   = 28,
    parameter int RATIO_L2   = 24,
    localparam int IDX_W     = $clog2(NUM_REGS),
    localparam int CNT_W     = $clog2(WINDOW + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ins_valid,
    input  logic               ins_vec,
    input  logic [1:0]         ins_width,
    input  logic               ins_fp_heavy,
    input  logic               ins_dst_we,
    input  logic [IDX_W-1:0]   ins_dst_idx,
    input  logic               ins_dst_mask,
    input  logic               ins_zero_upper,
    input  logic               restore_strobe,
    input  logic               restore_dirty,
    input  logic [HOLD_W-1:0]  hold_cycles,
    input  logic [CNT_W-1:0]   tp_threshold,
    output logic [1:0]         license,
    output logic [RATIO_W-1:0] freq_ratio,
    output logic               dirty_upper
);

    lic_t demand;
    lic_t lic_q;

    vlt_dirty_tracker #(
        .NUM_REGS (NUM_REGS),
        .KEY_REGS (KEY_REGS)
    ) u_dirty (
        .clk            (clk),
        .rst_n          (rst_n),
        .ins_valid      (ins_valid),
        .ins_width      (ins_width),
        .ins_dst_we     (ins_dst_we),
        .ins_dst_idx    (ins_dst_idx),
        .ins_dst_mask   (ins_dst_mask),
        .ins_zero_upper (ins_zero_upper),
        .restore_strobe (restore_strobe),
        .restore_dirty  (restore_dirty),
        .dirty          (dirty_upper)
    );

    vlt_demand #(
        .WINDOW (WINDOW)
    ) u_demand (
        .clk            (clk),
        .rst_n          (rst_n),
        .ins_valid      (ins_valid),
        .ins_vec        (ins_vec),
        .ins_width      (ins_width),
        .ins_fp_heavy   (ins_fp_heavy),
        .ins_zero_upper (ins_zero_upper),
        .dirty          (dirty_upper),
        .tp_threshold   (tp_threshold),
        .demand         (demand)
    );

    vlt_license_ctrl #(
        .HOLD_W (HOLD_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .demand      (demand),
        .hold_cycles (hold_cycles),
        .license     (lic_q)
    );

    // Map the granted license to its frequency ratio code.
    always_comb begin
        license = lic_q;
        unique case (lic_q)
            LIC_BASE: freq_ratio = RATIO_W'(RATIO_L0);
            LIC_MID:  freq_ratio = RATIO_W'(RATIO_L1);
            default:  freq_ratio = RATIO_W'(RATIO_L2);
        endcase
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (license == LIC_BASE && !dirty_upper)); // R1

    AST_RATIO_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (license > $past(license)) |-> (freq_ratio < $past(freq_ratio))); // R10

endmodule

// File: tb/vec_license_tracker_test.sv
`timescale 1ns/1ps
module vec_license_tracker_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ins_valid, ins_vec, ins_fp_heavy, ins_dst_we, ins_dst_mask;
    logic        ins_zero_upper, restore_strobe, restore_dirty;
    logic [1:0]  ins_width;
    logic [4:0]  ins_dst_idx;
    logic [15:0] hold_cycles;
    logic [3:0]  tp_threshold;
    logic [1:0]  license;
    logic [7:0]  freq_ratio;
    logic        dirty_upper;

    int checks   = 0;
    int failures = 0;

    always #2 clk = ~clk;

    vec_license_tracker uut (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_vec(ins_vec),
        .ins_width(ins_width), .ins_fp_heavy(ins_fp_heavy), .ins_dst_we(ins_dst_we),
        .ins_dst_idx(ins_dst_idx), .ins_dst_mask(ins_dst_mask),
        .ins_zero_upper(ins_zero_upper), .restore_strobe(restore_strobe),
        .restore_dirty(restore_dirty), .hold_cycles(hold_cycles),
        .tp_threshold(tp_threshold), .license(license), .freq_ratio(freq_ratio),
        .dirty_upper(dirty_upper)
    );

    typedef struct packed {
        logic       pre_dirty;
        logic       vec;
        logic [1:0] width;
        logic       fp;
        logic       we;
        logic [4:0] idx;
        logic       mask;
        logic       zu;
        logic [1:0] exp_lic;
        logic       exp_dirty;
    } row_t;

    localparam int NROWS = 12;
    localparam row_t TBL [NROWS] = '{
        '{1'b0, 1'b1, 2'd3, 1'b0, 1'b1, 5'd3,  1'b0, 1'b0, 2'd1, 1'b1}, // R2 R6 key wide write
        '{1'b0, 1'b1, 2'd3, 1'b0, 1'b1, 5'd20, 1'b0, 1'b0, 2'd1, 1'b0}, // R3 high register
        '{1'b0, 1'b1, 2'd3, 1'b0, 1'b1, 5'd5,  1'b1, 1'b0, 2'd1, 1'b0}, // R3 mask destination
        '{1'b0, 1'b1, 2'd3, 1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 2'd1, 1'b0}, // R3 read only
        '{1'b1, 1'b1, 2'd0, 1'b1, 1'b0, 5'd0,  1'b0, 1'b0, 2'd1, 1'b1}, // R5 scalar fp dirty
        '{1'b1, 1'b1, 2'd1, 1'b0, 1'b1, 5'd9,  1'b0, 1'b0, 2'd1, 1'b1}, // R5 128 int dirty
        '{1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 2'd0, 1'b1}, // R5 gp integer
        '{1'b0, 1'b1, 2'd2, 1'b0, 1'b1, 5'd1,  1'b0, 1'b0, 2'd0, 1'b0}, // R6 256 int clean
        '{1'b0, 1'b1, 2'd1, 1'b0, 1'b1, 5'd2,  1'b0, 1'b0, 2'd0, 1'b0}, // R3 R6 narrow key write
        '{1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 5'd0,  1'b0, 1'b1, 2'd0, 1'b0}, // R4 zero upper
        '{1'b0, 1'b1, 2'd2, 1'b1, 1'b0, 5'd0,  1'b0, 1'b0, 2'd0, 1'b0}, // R7 lone heavy 256
        '{1'b1, 1'b1, 2'd2, 1'b0, 1'b1, 5'd7,  1'b0, 1'b0, 2'd1, 1'b1}  // R5 256 write dirty
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        ins_valid = 0; ins_vec = 0; ins_width = 0; ins_fp_heavy = 0;
        ins_dst_we = 0; ins_dst_idx = 0; ins_dst_mask = 0; ins_zero_upper = 0;
        restore_strobe = 0; restore_dirty = 0;
    endtask

    task automatic op(input logic v, input logic [1:0] w, input logic fp,
                      input logic we, input logic [4:0] idx, input logic m,
                      input logic zu);
        idle();
        ins_valid = 1; ins_vec = v; ins_width = w; ins_fp_heavy = fp;
        ins_dst_we = we; ins_dst_idx = idx; ins_dst_mask = m; ins_zero_upper = zu;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        idle();
        rst_n = 0;
        step();
        step();
        rst_n = 1;
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        hold_cycles = 16'd1000;
        tp_threshold = 4'd3;
        @(negedge clk);
        do_reset();
        check("R1 license", license, 0);
        check("R1 R10 ratio", freq_ratio, 32);
        check("R1 dirty", dirty_upper, 0);

        for (int i = 0; i < NROWS; i++) begin
            do_reset();
            idle();
            restore_strobe = 1; restore_dirty = TBL[i].pre_dirty;
            step();
            op(TBL[i].vec, TBL[i].width, TBL[i].fp, TBL[i].we, TBL[i].idx,
               TBL[i].mask, TBL[i].zu);
            step();
            idle();
            check($sformatf("R2-table row %0d license", i), license, TBL[i].exp_lic);
            check($sformatf("R3-table row %0d dirty", i), dirty_upper, TBL[i].exp_dirty);
        end

        // R7: three heavy 256 ops in a row reach the threshold on the third
        do_reset();
        op(1, 2'd2, 1, 0, 0, 0, 0); step();
        check("R7 heavy256 first", license, 0);
        op(1, 2'd2, 1, 0, 0, 0, 0); step();
        check("R7 heavy256 second", license, 0);
        op(1, 2'd2, 1, 0, 0, 0, 0); step();
        idle();
        check("R7 heavy256 third", license, 1);
        check("R10 ratio level1", freq_ratio, 28);

        // R7: spaced ops fall out of the window
        do_reset();
        op(1, 2'd2, 1, 0, 0, 0, 0); step();
        idle(); step(); step(); step();
        op(1, 2'd2, 1, 0, 0, 0, 0); step();
        idle(); step(); step(); step();
        op(1, 2'd2, 1, 0, 0, 0, 0); step();
        check("R7 window slid", license, 0);
        op(1, 2'd2, 1, 0, 0, 0, 0); step();
        idle();
        check("R7 window full", license, 1);

        // R7 R8 R9: heavy 512 reaches level 2, then steps down with hold 3
        do_reset();
        hold_cycles = 16'd3;
        op(1, 2'd3, 1, 0, 0, 0, 0); step();
        check("R6 heavy512 first", license, 1);
        op(1, 2'd3, 1, 0, 0, 0, 0); step();
        op(1, 2'd3, 1, 0, 0, 0, 0); step();
        idle();
        check("R7 heavy512 third", license, 2);
        check("R10 ratio level2", freq_ratio, 24);
        step();
        check("R9 hold quiet1", license, 2);
        step();
        check("R9 hold quiet2", license, 2);
        step();
        check("R9 drop to 1", license, 1);
        step();
        op(1, 2'd3, 0, 0, 0, 0, 0); step();
        idle();
        check("R9 same level restarts", license, 1);
        step();
        step();
        check("R9 still held", license, 1);
        step();
        check("R9 drop to 0", license, 0);
        check("R10 ratio back", freq_ratio, 32);

        // R8: skip straight from 0 to 2 with threshold 1
        do_reset();
        tp_threshold = 4'd1;
        op(1, 2'd3, 1, 0, 0, 0, 0); step();
        idle();
        check("R8 jump to 2", license, 2);

        // R4: restore beats zeroing in the same cycle
        do_reset();
        op(1, 2'd0, 0, 0, 0, 0, 1);
        restore_strobe = 1; restore_dirty = 1;
        step();
        idle();
        check("R4 restore priority", dirty_upper, 1);
        check("R4 zeroing requests 0", license, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule